// File: doc/BRIEF.md
# Multi-Candidate Vote Counter

This block keeps a running vote count for each of eight candidates. On every clock edge where the vote-valid input is high, a 3-bit candidate code is decoded into a one-hot write enable. That enable steers the output of a single shared increment path into one of eight tally registers. The increment path reads the chosen candidate's present count, adds one and writes the result back.

A separate 3-bit display select picks one tally through a multiplexer and drives it onto the display output. The display select has no effect on counting, and the vote inputs have no effect on which tally is displayed. A synchronous reset clears every tally.

The vote input works as a stream with valid only. The block accepts a vote on every cycle in which `vote_valid` is high, so it never applies back-pressure. Consecutive cycles with valid high each count as a separate vote.

Top module: `vote_tally_top`

## Requirements
- R1: A clock edge with `rst` high sets all eight tallies to zero.
- R2: A clock edge with `vote_valid` high and `rst` low adds exactly one to the tally whose index equals `vote_cand` (binary code 0 to 7).
- R3: On an accepted vote, the seven tallies not named by `vote_cand` keep their values, so at most one tally changes per clock.
- R4: A clock edge with `vote_valid` low leaves every tally unchanged, whatever value `vote_cand` holds.
- R5: `show_tally` equals the tally whose index is `show_sel`, with no clock delay. It follows a change of `show_sel` in the same cycle and is unaffected by `vote_cand` while `vote_valid` is low.
- R6: A tally that holds its all-ones value and receives a vote becomes zero, and no other tally changes.
- R7: When `rst` and `vote_valid` are both high at the same edge, the reset wins and all tallies read zero afterwards.
- R8: Votes on consecutive cycles are each counted, with no cycle lost. N back-to-back votes for one candidate raise its tally by N.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; all state changes on its rising edge |
| rst | input | 1 | Synchronous reset, active high |
| vote_valid | input | 1 | Marks a vote on this cycle; always accepted |
| vote_cand | input | 3 | Candidate code of the vote |
| show_sel | input | 3 | Index of the tally to display |
| show_tally | output | TALLY_W (32) | Count of the selected candidate |

## Verification
A single vote per candidate shows that the decoder reaches each register and leaves the others alone. Idle cycles with a changing candidate code separate "valid gates the write" from "code alone writes". A long run of back-to-back votes to one candidate exposes lost or doubled counts in the shared increment path. A long pseudo-random run with valid toggling, compared against a reference tally, catches mis-steering between candidates. A narrow-width instance driven to its all-ones value checks wrap-around, and a vote arriving together with reset checks reset priority.

// File: rtl/vote_pkg.sv
`timescale 1ns/1ps
package vote_pkg;
  localparam int unsigned CAND_W_DEF  = 3;
  localparam int unsigned TALLY_W_DEF = 32;
endpackage

// File: rtl/vote_decode.sv
`timescale 1ns/1ps
// Candidate code to one-hot write enable, gated by vote valid.
module vote_decode #(
  parameter int unsigned CAND_W = vote_pkg::CAND_W_DEF,
  localparam int unsigned N = 1 << CAND_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              valid,
  input  logic [CAND_W-1:0] cand,
  output logic [N-1:0]      we
);
  always_comb begin
    we = '0;
    if (valid) we[cand] = 1'b1;
  end

  // R3: never more than one enable at a time
  assert_single_enable_R3: assert property (@(posedge clk) disable iff (rst)
    $onehot0(we));
  // R4: no enable without a valid vote
  assert_idle_no_write_R4: assert property (@(posedge clk) disable iff (rst)
    !valid |-> (we == '0));
  // R2: a valid vote always produces an enable
  assert_vote_enables_R2: assert property (@(posedge clk) disable iff (rst)
    valid |-> ($countones(we) == 1));
endmodule

// File: rtl/tally_pick.sv
`timescale 1ns/1ps
// Selects one word out of a bank of tallies.
module tally_pick #(
  parameter int unsigned SEL_W = vote_pkg::CAND_W_DEF,
  parameter int unsigned W     = vote_pkg::TALLY_W_DEF,
  localparam int unsigned N = 1 << SEL_W
) (
  input  logic [N-1:0][W-1:0] bank,
  input  logic [SEL_W-1:0]    sel,
  output logic [W-1:0]        word
);
  assign word = bank[sel];
endmodule

// File: rtl/tally_bank.sv
`timescale 1ns/1ps
// Eight (2**CAND_W) tally registers sharing one write-data bus.
module tally_bank #(
  parameter int unsigned N = 8,
  parameter int unsigned W = vote_pkg::TALLY_W_DEF
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [N-1:0]      we,
  input  logic [W-1:0]      wdata,
  output logic [N-1:0][W-1:0] tally
);
  logic rst_d1;
  always_ff @(posedge clk) rst_d1 <= rst;

  for (genvar i = 0; i < N; i++) begin : g_reg
    always_ff @(posedge clk) begin
      if (rst)        tally[i] <= '0;
      else if (we[i]) tally[i] <= wdata;
    end

    // R2: an enabled register advances by exactly one
    assert_step_one_R2: assert property (@(posedge clk) disable iff (rst)
      we[i] |=> (tally[i] == W'($past(tally[i]) + 1'b1)));
    // R4: a register without enable holds
    assert_hold_R4: assert property (@(posedge clk) disable iff (rst)
      !we[i] |=> $stable(tally[i]));
    // R6: all-ones wraps to zero
    assert_wrap_zero_R6: assert property (@(posedge clk) disable iff (rst)
      (we[i] && (tally[i] == '1)) |=> (tally[i] == '0));

    // R1: one edge after reset every register is zero
    always @(posedge clk) begin
      if (rst_d1) begin
        assert_reset_clear_R1: assert (tally[i] == '0);
      end
    end
  end
endmodule

// File: rtl/vote_tally_top.sv
`timescale 1ns/1ps
// Vote counter: decoder, shared +1 path, register bank, display mux.
module vote_tally_top #(
  parameter int unsigned CAND_W  = vote_pkg::CAND_W_DEF,
  parameter int unsigned TALLY_W = vote_pkg::TALLY_W_DEF
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               vote_valid,
  input  logic [CAND_W-1:0]  vote_cand,
  input  logic [CAND_W-1:0]  show_sel,
  output logic [TALLY_W-1:0] show_tally
);
  localparam int unsigned N = 1 << CAND_W;

  logic [N-1:0]              we;
  logic [N-1:0][TALLY_W-1:0] tally;
  logic [TALLY_W-1:0]        cur;
  logic [TALLY_W-1:0]        bump;

  vote_decode #(.CAND_W(CAND_W)) u_dec (
    .clk(clk), .rst(rst), .valid(vote_valid), .cand(vote_cand), .we(we)
  );

  // operand side of the shared increment path
  tally_pick #(.SEL_W(CAND_W), .W(TALLY_W)) u_opnd (
    .bank(tally), .sel(vote_cand), .word(cur)
  );

  assign bump = cur + 1'b1;

  tally_bank #(.N(N), .W(TALLY_W)) u_bank (
    .clk(clk), .rst(rst), .we(we), .wdata(bump), .tally(tally)
  );

  // display side
  tally_pick #(.SEL_W(CAND_W), .W(TALLY_W)) u_show (
    .bank(tally), .sel(show_sel), .word(show_tally)
  );

  // R7: reset beats a simultaneous vote
  assert_reset_wins_R7: assert property (@(posedge clk)
    (rst && vote_valid) |=> (tally[$past(vote_cand)] == '0));
endmodule

// File: tb/sim_vote_tally_top.sv
`timescale 1ns/1ps
module sim_vote_tally_top;
  localparam int unsigned CW = 3;
  localparam int unsigned TW = 32;
  localparam int unsigned NW = 4;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          vote_valid = 1'b0;
  logic [CW-1:0] vote_cand = '0;
  logic [CW-1:0] show_sel = '0;
  logic [TW-1:0] show_tally;

  logic          w_valid = 1'b0;
  logic [CW-1:0] w_cand = '0;
  logic [CW-1:0] w_sel = '0;
  logic [NW-1:0] w_tally;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;
  logic [TW-1:0] ref_t [8];

  always #2.5 clk = ~clk;

  vote_tally_top #(.CAND_W(CW), .TALLY_W(TW)) u0 (
    .clk(clk), .rst(rst), .vote_valid(vote_valid), .vote_cand(vote_cand),
    .show_sel(show_sel), .show_tally(show_tally)
  );

  vote_tally_top #(.CAND_W(CW), .TALLY_W(NW)) u_wrap (
    .clk(clk), .rst(rst), .vote_valid(w_valid), .vote_cand(w_cand),
    .show_sel(w_sel), .show_tally(w_tally)
  );

  task automatic chk(input string req, input logic [TW-1:0] got, input logic [TW-1:0] exp);
    checks++;
    if (got !== exp) begin
      failures++;
      $display("FAIL %s got=%0d expected=%0d", req, got, exp);
    end
  endtask

  // compares every tally with the reference, called just after a negedge
  task automatic check_all(input string req);
    for (int s = 0; s < 8; s++) begin
      show_sel = CW'(s);
      #0.2;
      chk(req, show_tally, ref_t[s]);
    end
  endtask

  task automatic vote(input bit v, input int c);
    vote_valid = v;
    vote_cand  = CW'(c);
    @(negedge clk);
    if (v) ref_t[c] = ref_t[c] + 1;
    vote_valid = 1'b0;
  endtask

  task automatic t_reset;
    rst = 1'b1;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    for (int i = 0; i < 8; i++) ref_t[i] = '0;
    check_all("R1");
  endtask

  task automatic t_single;
    for (int c = 0; c < 8; c++) begin
      vote(1'b1, c);
      check_all("R2/R3");
    end
  endtask

  task automatic t_idle;
    for (int c = 0; c < 8; c++) vote(1'b0, 7 - c);
    check_all("R4");
  endtask

  task automatic t_stream;
    vote_valid = 1'b1;
    vote_cand  = 3'd5;
    repeat (20) @(negedge clk);
    vote_valid = 1'b0;
    ref_t[5] = ref_t[5] + 20;
    check_all("R8");
  endtask

  task automatic t_random;
    for (int n = 0; n < 400; n++) begin
      int c;
      bit v;
      c = int'($urandom_range(0, 7));
      v = ($urandom_range(0, 3) != 0);
      vote(v, c);
    end
    check_all("R2/R3/R4");
  endtask

  task automatic t_display;
    show_sel = 3'd5;
    #0.2;
    for (int c = 0; c < 8; c++) begin
      vote_cand = CW'(c);
      #0.1;
      chk("R5", show_tally, ref_t[5]);
    end
    show_sel = 3'd0;
    #0.2;
    chk("R5", show_tally, ref_t[0]);
    @(negedge clk);
  endtask

  task automatic t_reset_priority;
    rst = 1'b1;
    vote_valid = 1'b1;
    vote_cand = 3'd4;
    @(negedge clk);
    rst = 1'b0;
    vote_valid = 1'b0;
    for (int i = 0; i < 8; i++) ref_t[i] = '0;
    check_all("R7");
  endtask

  task automatic t_wrap;
    w_cand = 3'd3;
    w_valid = 1'b1;
    repeat (15) @(negedge clk);
    w_valid = 1'b0;
    w_sel = 3'd3;
    #0.2;
    chk("R6", TW'(w_tally), 32'd15);
    w_valid = 1'b1;
    @(negedge clk);
    w_valid = 1'b0;
    #0.2;
    chk("R6", TW'(w_tally), 32'd0);
    w_sel = 3'd2;
    #0.2;
    chk("R6", TW'(w_tally), 32'd0);
  endtask

  initial begin
    @(negedge clk);
    t_reset();
    t_single();
    t_idle();
    t_stream();
    t_display();
    t_random();
    t_reset_priority();
    t_wrap();
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    #200000;
    if (!done) begin
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule